// File: doc/BRIEF.md
# Dual-Channel UART Status Shadow Register Bank

This block collects live status from two UART channels and presents it to a host as three read-only 32-bit words at consecutive offsets. One word carries the receive and transmit FIFO fill levels of both channels. The next carries both channels' 6-bit interrupt identification codes, one qualification flag per channel, and a global qualification flag. The third passes through a global interrupt status word that other logic supplies. Because the words are adjacent, a host can fetch all of them in one sequential burst.

The qualification flag ("good data") is set for a channel when three things hold together. Its interrupt code is benign (no interrupt, receive data, receive timeout or transmit holding register empty). Its line status shows no error or break entry in the FIFO. It also shows no overrun. When the flag is set, the host may drain as many bytes as the level word reported without reading that channel's line status. The addressed word is captured whole in the strobe cycle and returned one clock later, so every field in a word describes the same instant.

Top module: `uart_stat_shadow`

## Requirements
- R1: After reset, rdValid is 0 and rdData is 0.
- R2: rdValid is 1 in exactly the cycle after a cycle with rdEn high, and 0 otherwise.
- R3: A read at offset 0x08 returns the receive level of channel 0 in bits 7:0, the receive level of channel 1 in bits 15:8, the transmit level of channel 0 in bits 23:16 and the transmit level of channel 1 in bits 31:24.
- R4: A read at offset 0x0C returns the channel 0 interrupt code in bits 5:0 and the channel 1 code in bits 11:6, with bits 15:12 and 30:18 reading 0.
- R5: The good-data flag of channel n (bit 16 for channel 0, bit 17 for channel 1 of the 0x0C word) is 0 unless that channel's code is 0x01, 0x04, 0x0C or 0x02. Any other code, for example 0x06, 0x00 or 0x3F, clears it.
- R6: A channel's good-data flag is 0 while its lsrBrkErr bit (line status bit 7: parity, framing or break in the FIFO) is 1.
- R7: A channel's good-data flag is 0 while its lsrOvrErr bit (line status bit 1: overrun) is 1.
- R8: Bit 31 of the 0x0C word equals the AND of bits 16 and 17.
- R9: A read at offset 0x10 returns gisIn unchanged.
- R10: A read at any other offset, including unaligned ones such as 0x09, returns 0.
- R11: rdData reflects the inputs as they were in the cycle rdEn was high. Later input changes do not alter it, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Byte offset of the word to read |
| rxLvl | input | 16 | Receive FIFO levels, channel n at [8n+7:8n] |
| txLvl | input | 16 | Transmit FIFO levels, channel n at [8n+7:8n] |
| isrCode | input | 12 | Interrupt identification codes, channel n at [6n+5:6n] |
| lsrBrkErr | input | 2 | Per-channel line status bit 7 (error or break in FIFO) |
| lsrOvrErr | input | 2 | Per-channel line status bit 1 (overrun) |
| gisIn | input | 32 | Global interrupt status word, supplied externally |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | High one cycle after a read strobe |

## Verification
Every result of this block is due exactly one clock after the rising edge that sees rdEn high. rdValid and rdData both settle after that edge. The driver samples the inputs and pushes the expected word in the strobe cycle. The monitor pops and compares on the falling edge that follows the capture edge, whenever rdValid is high. Inputs change only after the capture edge has passed, so back-to-back bursts with data changing every cycle test that each word reflects only its own strobe cycle.

// File: rtl/uart_shadow_pkg.sv
package uart_shadow_pkg;
  localparam int NCH    = 2;
  localparam int LVL_W  = 8;
  localparam int ISR_W  = 6;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam int GD_BASE    = 16;
  localparam int GLOBAL_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_LVL = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SRC = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_GIS = 8'h10;

  localparam logic [ISR_W-1:0] CODE_IDLE  = 6'h01;
  localparam logic [ISR_W-1:0] CODE_RXDAT = 6'h04;
  localparam logic [ISR_W-1:0] CODE_RXTMO = 6'h0C;
  localparam logic [ISR_W-1:0] CODE_THRE  = 6'h02;

  typedef struct packed {
    logic load;
    logic selLvl;
    logic selSrc;
    logic selGis;
  } rdStrobe_t;

  function automatic logic isBenignCode(input logic [ISR_W-1:0] code);
    return (code == CODE_IDLE) || (code == CODE_RXDAT) ||
           (code == CODE_RXTMO) || (code == CODE_THRE);
  endfunction
endpackage

// File: rtl/uart_shadow_ctrl.sv
module uart_shadow_ctrl
  import uart_shadow_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output rdStrobe_t     strb,
  output logic          rdValid
);
  always_comb begin
    strb.load   = rdEn;
    strb.selLvl = rdEn && (rdAddr == AW'(OFS_LVL));
    strb.selSrc = rdEn && (rdAddr == AW'(OFS_SRC));
    strb.selGis = rdEn && (rdAddr == AW'(OFS_GIS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdEn;
  end

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R2
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selLvl, strb.selSrc, strb.selGis})); // R10
endmodule

// File: rtl/uart_shadow_dp.sv
module uart_shadow_dp
  import uart_shadow_pkg::*;
#(
  parameter int CH = NCH,
  parameter int LW = LVL_W,
  parameter int IW = ISR_W,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdStrobe_t        strb,
  input  logic [CH*LW-1:0] rxLvl,
  input  logic [CH*LW-1:0] txLvl,
  input  logic [CH*IW-1:0] isrCode,
  input  logic [CH-1:0]    lsrBrkErr,
  input  logic [CH-1:0]    lsrOvrErr,
  input  logic [DW-1:0]    gisIn,
  output logic [DW-1:0]    rdData
);
  localparam int ISR_TOP = CH*IW;
  localparam int GD_TOP  = GD_BASE + CH;
  localparam int GB      = DW - 1;

  logic [CH-1:0] gdFlag;
  logic [DW-1:0] lvlWord;
  logic [DW-1:0] srcWord;
  logic [DW-1:0] nextWord;

  for (genvar ch = 0; ch < CH; ch++) begin : g_qual
    assign gdFlag[ch] = isBenignCode(isrCode[ch*IW +: IW]) &
                        ~lsrBrkErr[ch] & ~lsrOvrErr[ch];
  end

  always_comb begin
    lvlWord = '0;
    srcWord = '0;
    for (int ch = 0; ch < CH; ch++) begin
      lvlWord[ch*LW +: LW]      = rxLvl[ch*LW +: LW];
      lvlWord[(CH+ch)*LW +: LW] = txLvl[ch*LW +: LW];
      srcWord[ch*IW +: IW]      = isrCode[ch*IW +: IW];
      srcWord[GD_BASE + ch]     = gdFlag[ch];
    end
    srcWord[GB] = &gdFlag;
  end

  always_comb begin
    if (strb.selLvl)      nextWord = lvlWord;
    else if (strb.selSrc) nextWord = srcWord;
    else if (strb.selGis) nextWord = gisIn;
    else                  nextWord = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.load) rdData <= nextWord;
  end

  AST_GLOBAL_IS_AND: assert property (@(posedge clk) disable iff (!rstN)
    strb.selSrc |=> (rdData[GB] == (&rdData[GD_TOP-1:GD_BASE]))); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.selSrc |=> (rdData[GB-1:GD_TOP] == '0 &&
                     rdData[GD_BASE-1:ISR_TOP] == '0)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.selLvl && !strb.selSrc && !strb.selGis) |=> rdData == '0); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(rdData)); // R11
endmodule

// File: rtl/uart_stat_shadow.sv
module uart_stat_shadow
  import uart_shadow_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [NCH*LVL_W-1:0] rxLvl,
  input  logic [NCH*LVL_W-1:0] txLvl,
  input  logic [NCH*ISR_W-1:0] isrCode,
  input  logic [NCH-1:0]       lsrBrkErr,
  input  logic [NCH-1:0]       lsrOvrErr,
  input  logic [DATA_W-1:0]    gisIn,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid
);
  rdStrobe_t strb;

  uart_shadow_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .strb(strb), .rdValid(rdValid)
  );

  uart_shadow_dp #(.CH(NCH), .LW(LVL_W), .IW(ISR_W), .DW(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxLvl(rxLvl), .txLvl(txLvl), .isrCode(isrCode),
    .lsrBrkErr(lsrBrkErr), .lsrOvrErr(lsrOvrErr),
    .gisIn(gisIn), .rdData(rdData)
  );
endmodule

// File: tb/sim_uart_stat_shadow.sv
module sim_uart_stat_shadow;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rx0 = '0, rx1 = '0, tx0 = '0, tx1 = '0;
  logic [5:0] i0 = 6'h01, i1 = 6'h01;
  logic b0 = 1'b0, b1 = 1'b0, o0 = 1'b0, o1 = 1'b0;
  logic [31:0] gis = '0;
  logic [31:0] rdData;
  logic rdValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stat_shadow u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .rxLvl({rx1, rx0}), .txLvl({tx1, tx0}), .isrCode({i1, i0}),
    .lsrBrkErr({b1, b0}), .lsrOvrErr({o1, o0}), .gisIn(gis),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic good(input logic [5:0] c, input logic brk, input logic ovr);
    return (c == 6'h01 || c == 6'h04 || c == 6'h0C || c == 6'h02) && !brk && !ovr;
  endfunction

  function automatic logic [31:0] model(input logic [7:0] a);
    logic g0, g1;
    g0 = good(i0, b0, o0);
    g1 = good(i1, b1, o1);
    case (a)
      8'h08: return {tx1, tx0, rx1, rx0};
      8'h0C: return {g0 & g1, 13'b0, g1, g0, 4'b0, i1, i0};
      8'h10: return gis;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: strobe at a falling edge, push expectation, return after capture edge.
  task automatic doRead(input logic [7:0] a, input string tag);
    @(negedge clk);
    rdEn = 1'b1;
    rdAddr = a;
    expQ.push_back(model(a));
    tagQ.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rdValid) begin
        if (expQ.size() == 0) begin
          check("R2 valid without read", 32'h1, 32'h0);
        end else begin
          check(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdValid", {31'b0, rdValid}, 32'h0);
    check("R1 rdData", rdData, 32'h0);

    // R3 level packing, two patterns
    rx0 = 8'h11; rx1 = 8'h22; tx0 = 8'h33; tx1 = 8'h44;
    doRead(8'h08, "R3");
    idle();
    rx0 = 8'hFF; rx1 = 8'h00; tx0 = 8'h80; tx1 = 8'h01;
    doRead(8'h08, "R3");
    idle();

    // R5 each benign code on both channels
    foreach (i0[k]) ; // no-op to keep loop-free style
    i0 = 6'h01; i1 = 6'h04; doRead(8'h0C, "R5 codes 01/04");
    i0 = 6'h0C; i1 = 6'h02; doRead(8'h0C, "R5 codes 0C/02");
    i0 = 6'h06; i1 = 6'h04; doRead(8'h0C, "R5 line status code");
    i0 = 6'h00; i1 = 6'h3F; doRead(8'h0C, "R5 modem and other codes");
    i0 = 6'h10; i1 = 6'h01; doRead(8'h0C, "R5 flow control code");
    idle();

    // R6, R7 line status bits
    i0 = 6'h04; i1 = 6'h04;
    b0 = 1'b1; doRead(8'h0C, "R6 ch0 break/error");
    b0 = 1'b0; b1 = 1'b1; doRead(8'h0C, "R6 ch1 break/error");
    b1 = 1'b0; o0 = 1'b1; doRead(8'h0C, "R7 ch0 overrun");
    o0 = 1'b0; o1 = 1'b1; doRead(8'h0C, "R7 ch1 overrun");
    o1 = 1'b0; doRead(8'h0C, "R8 both good");
    i1 = 6'h06; doRead(8'h0C, "R8 one bad");
    i0 = 6'h3F; doRead(8'h0C, "R4 reserved zero, full codes");
    idle();

    // R9 pass-through
    gis = 32'hA5C3_0F96; doRead(8'h10, "R9");
    gis = 32'hFFFF_FFFF; doRead(8'h10, "R9 all ones");
    idle();

    // R10 unmapped offsets
    doRead(8'h00, "R10 0x00");
    doRead(8'h09, "R10 0x09");
    doRead(8'h0E, "R10 0x0E");
    doRead(8'h14, "R10 0x14");
    doRead(8'hFC, "R10 0xFC");
    idle();

    // R11 burst with inputs changing every cycle
    i0 = 6'h02; i1 = 6'h0C; rx0 = 8'h05; rx1 = 8'h06; tx0 = 8'h07; tx1 = 8'h08;
    doRead(8'h08, "R11 burst levels");
    rx0 = 8'hEE; i0 = 6'h06; b1 = 1'b1;
    doRead(8'h0C, "R11 burst source");
    gis = 32'h1234_5678; i0 = 6'h01; b1 = 1'b0;
    doRead(8'h10, "R11 burst global");
    idle();

    // R11 hold while idle
    @(negedge clk);
    held = rdData;
    gis = 32'h0; rx0 = 8'h99; i0 = 6'h3F;
    repeat (3) @(negedge clk);
    check("R11 hold", rdData, held);
    check("R2 idle no valid", {31'b0, rdValid}, 32'h0);

    repeat (2) @(negedge clk);
    check("R2 all reads answered", expQ.size(), 32'h0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule